// File: doc/BRIEF.md
# Acquisition Status LED Controller

This block turns the status of one group of acquisition channels into drive levels for a row of indicator LEDs. Each channel reports whether its signal is valid, whether frame sync is held and whether its stream shows errors. The group reports whether its logic is configured, whether its FIFO is full and whether a status error is present. A serial test mode input is also provided.

Each LED is given one of three modes: dark, steadily lit or flashing. One LED per channel shows the state of that channel. Three group LEDs show overall activity, FIFO overflow and status errors. An internal prescaler divides the system clock down to a 1 Hz flash timebase with a 50% duty cycle, which all flashing LEDs share. The block does no decoding or sync detection of its own. It only maps status inputs that are already computed onto LED patterns, and it registers every LED output.

Top module: `acq_status_led`

## Requirements
- R1: A channel LED is dark while that channel's signal-valid input is low, whatever its sync and error inputs are. It is also dark when the signal is valid but the channel has neither sync nor errors.
- R2: A channel LED is steadily lit when its signal is valid, its frame sync is held and it has no error.
- R3: A channel LED flashes when its signal is valid and its error input is high. Error flashing takes priority over the steady sync indication.
- R4: With test mode low, the group activity LED is dark while the group is not configured.
- R5: With test mode low, the activity LED is steadily lit when the group is configured and at least one channel has both a valid signal and frame sync.
- R6: With test mode low, the activity LED flashes when the group is configured and no channel has both a valid signal and frame sync.
- R7: While test mode is high, the activity LED is steadily lit, even with no signal present and with the group unconfigured.
- R8: The FIFO LED flashes while the FIFO-full input is high and is dark otherwise.
- R9: The error LED is steadily lit while the status-error input is high and is dark otherwise.
- R10: A flashing LED repeats every CLK_HZ clock cycles and is lit for exactly CLK_HZ/2 consecutive cycles of each period. The cycle count CLK_HZ must be even and at least 2.
- R11: Every LED output is registered: it reflects inputs one clock edge after they change. All LEDs go dark as soon as the reset input (active low) is asserted and stay dark until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_valid | input | N_CHAN | Per-channel signal valid |
| chan_sync | input | N_CHAN | Per-channel frame sync held |
| chan_err | input | N_CHAN | Per-channel stream error |
| grp_configured | input | 1 | Group logic configured |
| fifo_full | input | 1 | Group FIFO full, data discarded |
| status_err | input | 1 | Group status error |
| test_mode | input | 1 | Serial test mode active |
| chan_led | output | N_CHAN | Channel LED drive, 1 = lit |
| act_led | output | 1 | Group activity LED drive |
| fifo_led | output | 1 | FIFO LED drive |
| err_led | output | 1 | Error LED drive |

## Verification
The bench builds the block with eight channels and CLK_HZ set to 8. This makes a flash period only eight cycles long, so a full lit and dark phase fits into a short observation window. Each LED is sampled over a whole period, and the number of lit samples tells the three modes apart: 0 for dark, 8 for steady and 4 for flashing. A 17-sample run counts the edges of the flash waveform. Separate scenarios cover the one-edge output latency and a reset asserted in the middle of activity.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

   // Display mode of one indicator
   typedef enum logic [1:0] {
      LED_OFF   = 2'd0,
      LED_ON    = 2'd1,
      LED_FLASH = 2'd2
   } led_mode_e;

endpackage

// File: rtl/led_flash_timebase.sv
module led_flash_timebase #(
   parameter int CLK_HZ = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int HALF = CLK_HZ / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   initial begin
      assert (CLK_HZ >= 2 && (CLK_HZ % 2) == 0)
         else $error("CLK_HZ must be even and at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         phase <= ~phase;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R10: the phase changes only when the half-period count wraps
   assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != LAST) |=> $stable(phase));
   assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/led_chan_decode.sv
module led_chan_decode
   import led_status_pkg::*;
(
   input  logic      valid,
   input  logic      sync,
   input  logic      err,
   output led_mode_e mode
);
   always_comb begin
      if (!valid)     mode = LED_OFF;    // R1
      else if (err)   mode = LED_FLASH;  // R3 takes priority
      else if (sync)  mode = LED_ON;     // R2
      else            mode = LED_OFF;
   end
endmodule

// File: rtl/led_group_decode.sv
module led_group_decode
   import led_status_pkg::*;
#(
   parameter int N_CHAN = 8
) (
   input  logic [N_CHAN-1:0] chan_valid,
   input  logic [N_CHAN-1:0] chan_sync,
   input  logic              configured,
   input  logic              fifo_full,
   input  logic              status_err,
   input  logic              test_mode,
   output led_mode_e         act_mode,
   output led_mode_e         fifo_mode,
   output led_mode_e         err_mode
);
   logic any_locked;
   assign any_locked = |(chan_valid & chan_sync);

   always_comb begin
      if (test_mode)        act_mode = LED_ON;     // R7
      else if (!configured) act_mode = LED_OFF;    // R4
      else if (any_locked)  act_mode = LED_ON;     // R5
      else                  act_mode = LED_FLASH;  // R6
   end

   assign fifo_mode = fifo_full  ? LED_FLASH : LED_OFF;  // R8
   assign err_mode  = status_err ? LED_ON    : LED_OFF;  // R9
endmodule

// File: rtl/led_drive.sv
module led_drive
   import led_status_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  led_mode_e mode,
   input  logic      phase,
   output logic      led_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q <= 1'b0;
      end else begin
         unique case (mode)
            LED_ON:    led_q <= 1'b1;
            LED_FLASH: led_q <= phase;
            default:   led_q <= 1'b0;
         endcase
      end
   end

   // R11: the registered level follows the mode presented one edge earlier
   assert_on_lit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LED_ON) |=> led_q);
   assert_off_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LED_OFF) |=> !led_q);
   assert_flash_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LED_FLASH) |=> (led_q == $past(phase)));

endmodule

// File: rtl/acq_status_led.sv
module acq_status_led
   import led_status_pkg::*;
#(
   parameter int N_CHAN = 8,
   parameter int CLK_HZ = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CHAN-1:0] chan_valid,
   input  logic [N_CHAN-1:0] chan_sync,
   input  logic [N_CHAN-1:0] chan_err,
   input  logic              grp_configured,
   input  logic              fifo_full,
   input  logic              status_err,
   input  logic              test_mode,
   output logic [N_CHAN-1:0] chan_led,
   output logic              act_led,
   output logic              fifo_led,
   output logic              err_led
);
   initial begin
      assert (N_CHAN >= 1) else $error("N_CHAN must be at least 1");
   end

   logic      phase;
   led_mode_e act_mode, fifo_mode, err_mode;

   led_flash_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
      .clk(clk), .rst_n(rst_n), .phase(phase)
   );

   led_group_decode #(.N_CHAN(N_CHAN)) u_grp (
      .chan_valid(chan_valid), .chan_sync(chan_sync),
      .configured(grp_configured), .fifo_full(fifo_full),
      .status_err(status_err), .test_mode(test_mode),
      .act_mode(act_mode), .fifo_mode(fifo_mode), .err_mode(err_mode)
   );

   for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
      led_mode_e cmode;

      led_chan_decode u_dec (
         .valid(chan_valid[i]), .sync(chan_sync[i]), .err(chan_err[i]),
         .mode(cmode)
      );

      led_drive u_drv (
         .clk(clk), .rst_n(rst_n), .mode(cmode), .phase(phase),
         .led_q(chan_led[i])
      );

      // R1: an invalid channel is dark on the next edge
      assert_invalid_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_valid[i] |=> !chan_led[i]);
   end

   led_drive u_act  (.clk(clk), .rst_n(rst_n), .mode(act_mode),  .phase(phase), .led_q(act_led));
   led_drive u_fifo (.clk(clk), .rst_n(rst_n), .mode(fifo_mode), .phase(phase), .led_q(fifo_led));
   led_drive u_err  (.clk(clk), .rst_n(rst_n), .mode(err_mode),  .phase(phase), .led_q(err_led));

   assert_test_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> act_led);
   assert_unconf_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_configured && !test_mode) |=> !act_led);
   assert_fifo_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_full |=> !fifo_led);
   assert_err_lit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      status_err |=> err_led);

endmodule

// File: tb/acq_status_led_tb.sv
module acq_status_led_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int HZ         = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic [N-1:0] chan_valid = '0, chan_sync = '0, chan_err = '0;
   logic         grp_configured = 1'b0, fifo_full = 1'b0;
   logic         status_err = 1'b0, test_mode = 1'b0;
   logic [N-1:0] chan_led;
   logic         act_led, fifo_led, err_led;

   int tests = 0, fails = 0;
   int cnt_ch [N];
   int cnt_act, cnt_fifo, cnt_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   acq_status_led #(.N_CHAN(N), .CLK_HZ(HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .chan_valid(chan_valid), .chan_sync(chan_sync),
      .chan_err(chan_err), .grp_configured(grp_configured), .fifo_full(fifo_full),
      .status_err(status_err), .test_mode(test_mode), .chan_led(chan_led),
      .act_led(act_led), .fifo_led(fifo_led), .err_led(err_led)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // settle two cycles, then count lit samples over one flash period
   task automatic observe();
      repeat (2) @(negedge clk);
      foreach (cnt_ch[i]) cnt_ch[i] = 0;
      cnt_act = 0; cnt_fifo = 0; cnt_err = 0;
      for (int k = 0; k < HZ; k++) begin
         @(negedge clk);
         for (int i = 0; i < N; i++) cnt_ch[i] += int'(chan_led[i]);
         cnt_act  += int'(act_led);
         cnt_fifo += int'(fifo_led);
         cnt_err  += int'(err_led);
      end
   endtask

   task automatic clear_inputs();
      chan_valid = '0; chan_sync = '0; chan_err = '0;
      grp_configured = 0; fifo_full = 0; status_err = 0; test_mode = 0;
   endtask

   task automatic t_reset_state();
      chk("R11 reset chan_led", int'(chan_led), 0);
      chk("R11 reset group", int'({act_led, fifo_led, err_led}), 0);
   endtask

   task automatic t_chan_modes();
      @(negedge clk);
      clear_inputs();
      grp_configured = 1;
      chan_valid = 8'b0001_1110; chan_sync = 8'b0000_0111; chan_err = 8'b0001_0101;
      observe();
      chk("R1 invalid ch0", cnt_ch[0], 0);
      chk("R2 locked ch1", cnt_ch[1], HZ);
      chk("R3 err+sync ch2", cnt_ch[2], HZ/2);
      chk("R1 valid no sync ch3", cnt_ch[3], 0);
      chk("R3 err no sync ch4", cnt_ch[4], HZ/2);
      chk("R1 idle ch7", cnt_ch[7], 0);
      chk("R5 act lit", cnt_act, HZ);
   endtask

   task automatic t_group_flash();
      @(negedge clk);
      clear_inputs();
      grp_configured = 1; chan_sync = 8'b0010_0000; chan_valid = 8'b1100_0000;
      observe();
      chk("R6 act flash no lock", cnt_act, HZ/2);
   endtask

   task automatic t_unconfigured();
      @(negedge clk);
      clear_inputs();
      chan_valid = 8'b0000_0010; chan_sync = 8'b0000_0010;
      observe();
      chk("R4 act dark unconfigured", cnt_act, 0);
      chk("R2 ch1 lit unconfigured", cnt_ch[1], HZ);
   endtask

   task automatic t_test_mode();
      @(negedge clk);
      clear_inputs();
      test_mode = 1;
      observe();
      chk("R7 act lit test unconf", cnt_act, HZ);
      @(negedge clk);
      grp_configured = 1;
      observe();
      chk("R7 act lit test no lock", cnt_act, HZ);
   endtask

   task automatic t_fifo_err();
      @(negedge clk);
      clear_inputs();
      fifo_full = 1; status_err = 1;
      observe();
      chk("R8 fifo flash", cnt_fifo, HZ/2);
      chk("R9 err lit", cnt_err, HZ);
      @(negedge clk);
      fifo_full = 0; status_err = 0;
      observe();
      chk("R8 fifo dark", cnt_fifo, 0);
      chk("R9 err dark", cnt_err, 0);
   endtask

   task automatic t_flash_shape();
      int edges = 0, run = 0, maxrun = 0;
      logic prev;
      @(negedge clk);
      clear_inputs();
      fifo_full = 1;
      repeat (2) @(negedge clk);
      prev = fifo_led;
      run = 1;
      for (int k = 0; k < 2*HZ; k++) begin
         @(negedge clk);
         if (fifo_led != prev) begin edges++; run = 1; end
         else run++;
         if (run > maxrun) maxrun = run;
         prev = fifo_led;
      end
      chk("R10 edges in two periods", edges, 4);
      chk("R10 longest run", maxrun, HZ/2);
   endtask

   task automatic t_latency();
      @(negedge clk);
      clear_inputs();
      repeat (2) @(negedge clk);
      chan_valid[6] = 1; chan_sync[6] = 1; status_err = 1;
      #1;
      chk("R11 no comb path ch6", int'(chan_led[6]), 0);
      chk("R11 no comb path err", int'(err_led), 0);
      @(negedge clk);
      chk("R11 one edge ch6", int'(chan_led[6]), 1);
      chk("R11 one edge err", int'(err_led), 1);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      clear_inputs();
      chan_valid = '1; chan_sync = '1; test_mode = 1; status_err = 1;
      repeat (3) @(negedge clk);
      rst_n = 0;
      #1;
      chk("R11 mid reset chan", int'(chan_led), 0);
      chk("R11 mid reset group", int'({act_led, fifo_led, err_led}), 0);
      repeat (2) @(negedge clk);
      chk("R11 held in reset", int'({chan_led, act_led, err_led}), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R11 after release", int'(act_led), 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1 rst_n = 0;
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1;
      t_chan_modes();
      t_group_flash();
      t_unconfigured();
      t_test_mode();
      t_fifo_err();
      t_flash_shape();
      t_latency();
      t_reset_mid();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule